// File: doc/BRIEF.md
# 1-Wire ROM Search Controller

This block enumerates the devices on a 1-Wire bus by walking the binary tree of their 64-bit identifiers. It does not drive the wire itself. It issues operations to a separate bus timing engine through a command/response handshake and consumes the bits that the engine samples. A run begins with a start strobe. The controller sends the search command byte. Then, for each identifier bit from index 0 to 63, it reads the bit and its complement and writes back the bit it has chosen. The run ends with a one-cycle done pulse.

Between runs the controller keeps a single stored conflict position, where the value 64 means that no conflict is stored. When a conflict occurs at the stored position, the controller takes the 1 branch. When a conflict occurs anywhere else, it takes the 0 branch and records that index as the current conflict. The current conflict replaces the stored one at the end of every run, including an aborted run. An 8-bit CRC with reflected polynomial 0x8C runs over the 64 chosen bits. A nonzero residue marks the identifier as invalid and zeroes the reported identifier.

The caller must reset the bus before each run. The match and skip commands are handled outside this block.

Top module: `owsc_search_ctrl`

## Requirements
- R1: On start_i the controller issues one write-byte operation (cmd_op_o = 0, byte on cmd_data_o, sent LSB first by the engine). The byte is 0xF0 when alarm_i is low at the start strobe and 0xEC when alarm_i is high.
- R2: After the command byte, for each index 0 to 63 in ascending order, the controller issues two read-bit operations (cmd_op_o = 1) and then one write-bit operation (cmd_op_o = 2). The bit to send is on cmd_data_o[0] and cmd_data_o[7:1] are zero.
- R3: A read pair with first = 1 and second = 0 selects identifier bit 1. A pair with first = 0 and second = 1 selects bit 0. The selected bit is stored at rom_id_o[index] and is also the bit that is written back.
- R4: A pair (0,0) is a conflict. At the stored conflict position the bit becomes 1. At any other index the bit becomes 0 and that index becomes the current conflict, so the last such index wins.
- R5: A pair (1,1) aborts the run. done_o pulses, no_dev_o goes to 1, crc_ok_o stays 0, and the stored conflict takes the current-conflict value.
- R6: If the stored conflict is 64 when a run starts, rom_id_o is cleared to zero. Otherwise the previous identifier remains until its bits are overwritten.
- R7: At the end of a run, the stored conflict takes the current-conflict value, and more_o is 1 exactly when that value is below 64.
- R8: After all 64 bits, crc_ok_o is 1 when the CRC residue is zero. Otherwise crc_ok_o is 0 and rom_id_o is forced to zero.
- R9: Reset sets the stored conflict to 64 and all outputs to zero. While no run is active, restart_i sets the stored conflict to 64 and clears more_o.
- R10: cmd_valid_o, cmd_op_o and cmd_data_o stay stable until rsp_valid_i. cmd_valid_o is low whenever busy_o is low, and done_o lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one search run |
| restart_i | input | 1 | Forget the stored conflict (honoured when idle) |
| alarm_i | input | 1 | Select the alarm-only search command |
| cmd_valid_o | output | 1 | Operation request to the timing engine |
| cmd_op_o | output | 2 | 0 write byte, 1 read bit, 2 write bit |
| cmd_data_o | output | 8 | Byte to write, or the bit in [0] |
| rsp_valid_i | input | 1 | Engine finished the requested operation |
| rsp_bit_i | input | 1 | Sampled bus bit for a read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| rom_id_o | output | 64 | Discovered identifier |
| more_o | output | 1 | A further branch remains to be searched |
| no_dev_o | output | 1 | Last run aborted on a (1,1) pair |
| crc_ok_o | output | 1 | Last run completed with a valid CRC |

## Verification
The hardest situation to reach is an abort while a conflict is stored. In that case the identifier must not be cleared at the start of the run, and the stored value must then collapse to 64. The bench gets there by first searching a three-device population. That leaves conflict index 2 stored. The bench then runs twice against an empty bus. It also uses three devices whose identifiers split at bits 2 and 5. This shows that a fresh conflict below the stored position sends the search back down the 0 branch.

// File: rtl/owsc_pkg.sv
package owsc_pkg;
  typedef enum logic [1:0] {
    OP_WR_BYTE = 2'd0,
    OP_RD_BIT  = 2'd1,
    OP_WR_BIT  = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RD_A, ST_RD_B, ST_WR, ST_FIN
  } state_e;
endpackage

// File: rtl/owsc_crc8.sv
module owsc_crc8 #(
  parameter logic [7:0] POLY = 8'h8C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [7:0] crc_o
);
  logic fb;
  assign fb = crc_o[0] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= (crc_o >> 1) ^ (fb ? POLY : 8'h00);
  end
endmodule

// File: rtl/owsc_branch.sv
module owsc_branch #(
  parameter int POS_W = 7
) (
  input  logic             first_i,
  input  logic             second_i,
  input  logic [POS_W-1:0] idx_i,
  input  logic [POS_W-1:0] stored_i,
  output logic             bit_o,
  output logic             new_conf_o,
  output logic             none_o
);
  always_comb begin
    bit_o      = 1'b0;
    new_conf_o = 1'b0;
    none_o     = 1'b0;
    unique case ({first_i, second_i})
      2'b10: bit_o = 1'b1;
      2'b01: bit_o = 1'b0;
      2'b00: begin
        if (idx_i == stored_i) bit_o = 1'b1;
        else                   new_conf_o = 1'b1;
      end
      default: none_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/owsc_search_ctrl.sv
module owsc_search_ctrl
  import owsc_pkg::*;
#(
  parameter int         ID_W       = 64,
  parameter logic [7:0] CMD_SEARCH = 8'hF0,
  parameter logic [7:0] CMD_ALARM  = 8'hEC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            restart_i,
  input  logic            alarm_i,
  output logic            cmd_valid_o,
  output logic [1:0]      cmd_op_o,
  output logic [7:0]      cmd_data_o,
  input  logic            rsp_valid_i,
  input  logic            rsp_bit_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [ID_W-1:0] rom_id_o,
  output logic            more_o,
  output logic            no_dev_o,
  output logic            crc_ok_o
);
  localparam int POS_W = $clog2(ID_W + 1);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [POS_W-1:0] NONE = POS_W'(ID_W);
  localparam logic [POS_W-1:0] LAST = POS_W'(ID_W - 1);

  state_e           st;
  logic [POS_W-1:0] idx, cur_conf, stored_conf;
  logic             first_q, bit_q;
  logic [7:0]       cmd_q;
  logic             dec_bit, dec_new, dec_none;
  logic [7:0]       crc;
  logic             pair_done, launch;

  assign pair_done = (st == ST_RD_B) && rsp_valid_i;
  assign launch    = (st == ST_IDLE) && start_i;

  owsc_branch #(.POS_W(POS_W)) i_branch (
    .first_i   (first_q),
    .second_i  (rsp_bit_i),
    .idx_i     (idx),
    .stored_i  (stored_conf),
    .bit_o     (dec_bit),
    .new_conf_o(dec_new),
    .none_o    (dec_none)
  );

  owsc_crc8 i_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (launch),
    .en_i  (pair_done && !dec_none),
    .bit_i (dec_bit),
    .crc_o (crc)
  );

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_op_o    = OP_RD_BIT;
    cmd_data_o  = 8'h00;
    unique case (st)
      ST_SEND:         begin cmd_valid_o = 1'b1; cmd_op_o = OP_WR_BYTE; cmd_data_o = cmd_q; end
      ST_RD_A, ST_RD_B: cmd_valid_o = 1'b1;
      ST_WR:           begin cmd_valid_o = 1'b1; cmd_op_o = OP_WR_BIT; cmd_data_o = {7'd0, bit_q}; end
      default: ;
    endcase
  end

  assign busy_o = (st != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      idx         <= '0;
      cur_conf    <= NONE;
      stored_conf <= NONE;
      first_q     <= 1'b0;
      bit_q       <= 1'b0;
      cmd_q       <= '0;
      rom_id_o    <= '0;
      more_o      <= 1'b0;
      no_dev_o    <= 1'b0;
      crc_ok_o    <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            st       <= ST_SEND;
            cmd_q    <= alarm_i ? CMD_ALARM : CMD_SEARCH;
            idx      <= '0;
            cur_conf <= NONE;
            no_dev_o <= 1'b0;
            crc_ok_o <= 1'b0;
            if (stored_conf == NONE) rom_id_o <= '0;
          end else if (restart_i) begin
            stored_conf <= NONE;
            more_o      <= 1'b0;
          end
        end
        ST_SEND: if (rsp_valid_i) st <= ST_RD_A;
        ST_RD_A: if (rsp_valid_i) begin
          first_q <= rsp_bit_i;
          st      <= ST_RD_B;
        end
        ST_RD_B: if (rsp_valid_i) begin
          if (dec_none) begin
            stored_conf <= cur_conf;
            more_o      <= (cur_conf != NONE);
            no_dev_o    <= 1'b1;
            done_o      <= 1'b1;
            st          <= ST_IDLE;
          end else begin
            rom_id_o[idx[IDX_W-1:0]] <= dec_bit;
            bit_q <= dec_bit;
            if (dec_new) cur_conf <= idx;
            st <= ST_WR;
          end
        end
        ST_WR: if (rsp_valid_i) begin
          if (idx == LAST) st <= ST_FIN;
          else begin
            idx <= idx + 1'b1;
            st  <= ST_RD_A;
          end
        end
        ST_FIN: begin
          stored_conf <= cur_conf;
          more_o      <= (cur_conf != NONE);
          crc_ok_o    <= (crc == 8'h00);
          if (crc != 8'h00) rom_id_o <= '0;
          done_o      <= 1'b1;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owsc_search_ctrl_chk.sv
module owsc_search_ctrl_chk #(
  parameter int ID_W = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_o,
  input logic [1:0]      cmd_op_o,
  input logic [7:0]      cmd_data_o,
  input logic            rsp_valid_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [ID_W-1:0] rom_id_o,
  input logic            more_o,
  input logic            no_dev_o,
  input logic            crc_ok_o
);
  p_cmd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !rsp_valid_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_abort_no_crc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_dev_o |-> !crc_ok_o);

  p_bad_crc_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !no_dev_o && !crc_ok_o |-> rom_id_o == '0);

  p_more_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(more_o) |-> done_o);
endmodule

bind owsc_search_ctrl owsc_search_ctrl_chk #(.ID_W(ID_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_o(cmd_valid_o),
  .cmd_op_o   (cmd_op_o),
  .cmd_data_o (cmd_data_o),
  .rsp_valid_i(rsp_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rom_id_o   (rom_id_o),
  .more_o     (more_o),
  .no_dev_o   (no_dev_o),
  .crc_ok_o   (crc_ok_o)
);

// File: tb/test_owsc_search_ctrl.sv
`timescale 1ns/1ps
module test_owsc_search_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, restart_i = 1'b0, alarm_i = 1'b0;
  logic        cmd_valid_o;
  logic [1:0]  cmd_op_o;
  logic [7:0]  cmd_data_o;
  logic        rsp_valid_i = 1'b0, rsp_bit_i = 1'b0;
  logic        busy_o, done_o, more_o, no_dev_o, crc_ok_o;
  logic [63:0] rom_id_o;

  always #10 clk_i = ~clk_i;

  owsc_search_ctrl i_owsc_search_ctrl (.*);

  int n_run = 0, n_fail = 0;

  // device population and engine model
  logic [63:0] dev [3];
  logic [2:0]  present = 3'b000;
  logic [2:0]  active;
  int          bpos;
  bit          rph;
  logic [63:0] wb;
  logic [7:0]  last_cmd;
  logic [1:0]  bad_op_seen = 2'b00;

  function automatic logic [7:0] crc_of(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] mk_id(input logic [55:0] d);
    return {crc_of(d), d};
  endfunction

  initial begin
    logic [1:0] op;
    logic [7:0] d;
    logic       r;
    forever begin
      @(negedge clk_i);
      if (rsp_valid_i) rsp_valid_i = 1'b0;
      else if (rst_ni && cmd_valid_o) begin
        op = cmd_op_o;
        d  = cmd_data_o;
        repeat (2) @(negedge clk_i);
        if (op == 2'd0) begin
          last_cmd = d; active = present; bpos = 0; rph = 0; wb = '0;
        end else if (op == 2'd1) begin
          r = 1'b1;
          for (int i = 0; i < 3; i++)
            if (active[i]) r = r & (rph ? ~dev[i][bpos] : dev[i][bpos]);
          rsp_bit_i = r;
          rph = ~rph;
        end else if (op == 2'd2) begin
          if (d[7:1] != 0) bad_op_seen = 2'b01;
          for (int i = 0; i < 3; i++)
            if (dev[i][bpos] != d[0]) active[i] = 1'b0;
          if (bpos < 64) wb[bpos] = d[0];
          bpos++; rph = 0;
        end else bad_op_seen = 2'b10;
        rsp_valid_i = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_search(input logic alarm);
    int n = 0;
    @(negedge clk_i);
    alarm_i = alarm; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && n < 5000) begin @(negedge clk_i); n++; end
    chk(done_o, "R10 done seen", {63'd0, done_o}, 64'd1);
    @(negedge clk_i);
    chk(!done_o, "R10 done one cycle", {63'd0, done_o}, 64'd0);
  endtask

  task automatic expect_run(input string tag, input logic [63:0] id, input bit more, input bit nodev, input bit crcok);
    chk(rom_id_o == id, {tag, " id"}, rom_id_o, id);
    chk(more_o == more, {tag, " more R7"}, {63'd0, more_o}, {63'd0, more});
    chk(no_dev_o == nodev, {tag, " no_dev R5"}, {63'd0, no_dev_o}, {63'd0, nodev});
    chk(crc_ok_o == crcok, {tag, " crc_ok R8"}, {63'd0, crc_ok_o}, {63'd0, crcok});
  endtask

  logic [55:0] base;
  logic [63:0] id_a, id_b, id_c;

  task automatic t_reset();
    chk(!busy_o && !done_o && !cmd_valid_o, "R9 reset idle", {61'd0, busy_o, done_o, cmd_valid_o}, 64'd0);
    chk(rom_id_o == 0 && !more_o && !no_dev_o && !crc_ok_o, "R9 reset outputs", rom_id_o, 64'd0);
  endtask

  task automatic t_single();
    dev[0] = id_a; present = 3'b001;
    run_search(1'b0);
    chk(last_cmd == 8'hF0, "R1 search byte", {56'd0, last_cmd}, 64'hF0);
    chk(wb == id_a, "R2 R3 written bits", wb, id_a);
    expect_run("R3 single", id_a, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_three();
    dev[0] = id_a; dev[1] = id_b; dev[2] = id_c; present = 3'b111;
    run_search(1'b0);
    expect_run("R4 three run1", id_a, 1'b1, 1'b0, 1'b1);
    run_search(1'b0);
    chk(wb == id_b, "R4 known conflict takes 1", wb, id_b);
    expect_run("R4 three run2", id_b, 1'b1, 1'b0, 1'b1);
    run_search(1'b0);
    expect_run("R4 new conflict takes 0", id_a, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_keep();
    present = 3'b000;
    run_search(1'b0);
    expect_run("R6 R5 abort keeps id", id_a, 1'b0, 1'b1, 1'b0);
    run_search(1'b0);
    expect_run("R6 abort clears id", 64'd0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_restart();
    dev[0] = id_a; dev[1] = id_b; present = 3'b011;
    run_search(1'b0);
    expect_run("R7 two run1", id_a, 1'b1, 1'b0, 1'b1);
    @(negedge clk_i); restart_i = 1'b1;
    @(negedge clk_i); restart_i = 1'b0;
    chk(!more_o, "R9 restart clears more", {63'd0, more_o}, 64'd0);
    run_search(1'b0);
    expect_run("R9 restart repeats first", id_a, 1'b1, 1'b0, 1'b1);
    run_search(1'b0);
    expect_run("R7 two run2", id_b, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_alarm();
    dev[0] = id_c; present = 3'b001;
    run_search(1'b1);
    chk(last_cmd == 8'hEC, "R1 alarm byte", {56'd0, last_cmd}, 64'hEC);
    expect_run("R1 alarm run", id_c, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_bad_crc();
    logic [63:0] bad;
    bad = id_b ^ 64'h0100_0000_0000_0000;
    dev[0] = bad; present = 3'b001;
    run_search(1'b0);
    chk(wb == bad, "R8 bits written", wb, bad);
    expect_run("R8 bad crc", 64'd0, 1'b0, 1'b0, 1'b0);
    chk(bad_op_seen == 2'b00, "R2 op encoding", {62'd0, bad_op_seen}, 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    base = {48'h0A1B2C3D4E5F, 8'h01};
    id_a = mk_id(base);
    id_b = mk_id(base | 56'h04);
    id_c = mk_id(base | 56'h24);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_single();
    t_three();
    t_keep();
    t_restart();
    t_alarm();
    t_bad_crc();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule